// File: doc/BRIEF.md
# Skip-Sample Shifted Word Reader

This block fetches one bit-field of a lattice whose sites are stored as skip samples. Memory holds the field as a sector of N sub-words, each `WORD_W` bits wide. Sub-word `a` carries the sites `a, a+N, a+2N, ...`, so one sub-word is one site group of evenly spaced sites. The block never moves data in memory to shift the field. It reads a sub-word at an offset from the current group and then rotates it, and the result is the field shifted by any distance. Sites that run past the end of the sector come back through the rotation.

A start pulse latches a shift amount and begins a sweep over all N site groups in order, one group per cycle. For each group the block issues a row address and a column address to a memory that returns a whole column word (`SUBS` sub-words) one cycle later. The block then selects the sub-word, rotates it, registers it and presents it with a valid strobe and its group number. A done strobe marks the last word of the sweep. Shifts of this kind feed lockstep processing elements that update every site of a group at once.

Top module: `skip_shift_reader`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, `busy_o`, `mem_rd_o`, `out_valid_o` and `done_o` are low.
- R2: Bit `j` of sub-word `a` holds site `a + j*N`, where N = ROWS*COLS*SUBS and the field has L = N*WORD_W sites. For a shift `s`, bit `k` of the output word for group `g` is site `(g + k*N + s) mod L`.
- R3: The low log2(N) bits of `shift_i` are the sub-word offset `d`. The high log2(WORD_W) bits are the base rotation `r`. Group `g` reads sub-word `(g+d) mod N` and rotates it right by `r`, plus one more position when `g+d >= N`, modulo WORD_W.
- R4: A sub-word address `a` is issued as sub-word `a mod SUBS` (bits `[WORD_W*sel +: WORD_W]` of the column word), column `(a / SUBS) mod COLS` and row `a / (SUBS*COLS)`.
- R5: Within a sweep, successive reads use sub-word addresses that increase by one modulo N, so the row changes only after its last column and last sub-word have been read.
- R6: Each output word appears with `out_valid_o` exactly two cycles after its read was issued on `mem_rd_o`. The memory returns the column word on the cycle after the read.
- R7: A sweep delivers exactly N words, with `out_group_o` counting 0 to N-1. `done_o` is high only together with the word of group N-1.
- R8: A start pulse that arrives while `busy_o` is high is ignored. The sweep in progress keeps its shift and its order.
- R9: `busy_o` rises on the cycle after a start is accepted, and the first read is issued on the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a sweep when idle |
| shift_i | input | log2(N)+log2(WORD_W) | Lattice shift distance, latched at start |
| busy_o | output | 1 | Sweep in progress |
| mem_rd_o | output | 1 | Read strobe to the memory |
| mem_row_o | output | log2(ROWS) | Row address |
| mem_col_o | output | log2(COLS) | Column address |
| mem_rdata_i | input | WORD_W*SUBS | Column word, valid the cycle after the read |
| out_valid_o | output | 1 | Output word valid |
| out_group_o | output | log2(N) | Site group of the output word |
| out_data_o | output | WORD_W | Shifted site-group word |
| done_o | output | 1 | Last word of the sweep |

## Verification
The bench uses a sector of sixteen sub-words and runs every one of the 1024 possible shifts. This covers zero shift, pure offsets, pure rotations and every mix of the two, including shifts where the offset wraps the sector and adds the extra rotation step. The field content is a hashed bit pattern, so a wrong offset, a missing or surplus rotation step, or a wrong sub-word select all change the data. Some sweeps receive a competing start pulse partway through. This shows whether the latched shift and the group order survive it.

// File: rtl/skip_pkg.sv
package skip_pkg;
  typedef struct packed {
    logic vld;
    logic last;
  } skip_tag_t;
endpackage

// File: rtl/skip_barrel_rot.sv
module skip_barrel_rot #(
  parameter int W = 64
) (
  input  logic [W-1:0]         din,
  input  logic [$clog2(W)-1:0] amt,
  output logic [W-1:0]         dout
);
  localparam int LV = $clog2(W);

  logic [W-1:0] stg [LV+1];

  assign stg[0] = din;

  // right rotation by 2**i per level: result bit k takes input bit k+2**i
  for (genvar i = 0; i < LV; i++) begin : g_lvl
    localparam int S = 1 << i;
    assign stg[i+1] = amt[i] ? {stg[i][S-1:0], stg[i][W-1:S]} : stg[i];
  end

  assign dout = stg[LV];
endmodule

// File: rtl/skip_subword_mux.sv
module skip_subword_mux #(
  parameter int W    = 64,
  parameter int SUBS = 4
) (
  input  logic [W*SUBS-1:0]       col_word,
  input  logic [$clog2(SUBS)-1:0] sel,
  output logic [W-1:0]            word
);
  localparam int SW = $clog2(SUBS);

  always_comb begin
    word = '0;
    for (int i = 0; i < SUBS; i++) begin
      if (sel == SW'(i)) word = col_word[i*W +: W];
    end
  end
endmodule

// File: rtl/skip_addr_seq.sv
module skip_addr_seq #(
  parameter int ROWS   = 4,
  parameter int COLS   = 8,
  parameter int SUBS   = 4,
  parameter int WORD_W = 64,
  localparam int N     = ROWS * COLS * SUBS,
  localparam int AW    = $clog2(N),
  localparam int RW    = $clog2(WORD_W),
  localparam int SW    = $clog2(SUBS),
  localparam int CW    = $clog2(COLS),
  localparam int RAW   = $clog2(ROWS),
  localparam int SHW   = AW + RW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [SHW-1:0] shift_i,
  output logic           busy_o,
  output logic           rd_o,
  output logic [RAW-1:0] row_o,
  output logic [CW-1:0]  col_o,
  output logic [SW-1:0]  sub_o,
  output logic [RW-1:0]  rot_o,
  output logic [AW-1:0]  grp_o,
  output logic           last_o
);
  logic          busy_q;
  logic [AW-1:0] cnt_q;
  logic [AW-1:0] ofs_q;
  logic [RW-1:0] rot_base_q;
  logic [AW-1:0] lin_q;
  logic [AW:0]   sum;

  assign sum = {1'b0, cnt_q} + {1'b0, ofs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      ofs_q      <= '0;
      rot_base_q <= '0;
      lin_q      <= '0;
      rd_o       <= 1'b0;
      rot_o      <= '0;
      grp_o      <= '0;
      last_o     <= 1'b0;
    end else begin
      rd_o   <= 1'b0;
      last_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q     <= 1'b1;
          cnt_q      <= '0;
          ofs_q      <= shift_i[AW-1:0];
          rot_base_q <= shift_i[SHW-1:AW];
        end
      end else begin
        rd_o   <= 1'b1;
        lin_q  <= sum[AW-1:0];
        rot_o  <= rot_base_q + {{(RW-1){1'b0}}, sum[AW]};
        grp_o  <= cnt_q;
        last_o <= (cnt_q == AW'(N-1));
        cnt_q  <= cnt_q + 1'b1;
        if (cnt_q == AW'(N-1)) busy_q <= 1'b0;
      end
    end
  end

  assign busy_o = busy_q;
  assign sub_o  = lin_q[SW-1:0];
  assign col_o  = lin_q[SW +: CW];
  assign row_o  = lin_q[SW+CW +: RAW];

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    rd_o && $past(rd_o) |-> lin_q == $past(lin_q) + 1'b1); // R5

  AST_ROW_WALK: assert property (@(posedge clk) disable iff (rst)
    rd_o && $past(rd_o) && (row_o != $past(row_o))
      |-> ($past(col_o) == CW'(COLS-1)) && ($past(sub_o) == SW'(SUBS-1))); // R5

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    busy_q && start_i |=> $stable(ofs_q) && $stable(rot_base_q)); // R8

  AST_FIRST_READ: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |=> rd_o); // R9
endmodule

// File: rtl/skip_shift_reader.sv
module skip_shift_reader #(
  parameter int ROWS   = 4,
  parameter int COLS   = 8,
  parameter int SUBS   = 4,
  parameter int WORD_W = 64,
  localparam int N     = ROWS * COLS * SUBS,
  localparam int AW    = $clog2(N),
  localparam int RW    = $clog2(WORD_W),
  localparam int SW    = $clog2(SUBS),
  localparam int CW    = $clog2(COLS),
  localparam int RAW   = $clog2(ROWS),
  localparam int SHW   = AW + RW,
  localparam int COL_W = WORD_W * SUBS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [SHW-1:0]    shift_i,
  output logic              busy_o,
  output logic              mem_rd_o,
  output logic [RAW-1:0]    mem_row_o,
  output logic [CW-1:0]     mem_col_o,
  input  logic [COL_W-1:0]  mem_rdata_i,
  output logic              out_valid_o,
  output logic [AW-1:0]     out_group_o,
  output logic [WORD_W-1:0] out_data_o,
  output logic              done_o
);
  import skip_pkg::*;

  logic [SW-1:0] iss_sub;
  logic [RW-1:0] iss_rot;
  logic [AW-1:0] iss_grp;
  logic          iss_last;

  skip_addr_seq #(
    .ROWS(ROWS), .COLS(COLS), .SUBS(SUBS), .WORD_W(WORD_W)
  ) i_seq (
    .clk(clk), .rst(rst), .start_i(start_i), .shift_i(shift_i),
    .busy_o(busy_o), .rd_o(mem_rd_o), .row_o(mem_row_o), .col_o(mem_col_o),
    .sub_o(iss_sub), .rot_o(iss_rot), .grp_o(iss_grp), .last_o(iss_last)
  );

  // stage 1: aligned with the memory read
  skip_tag_t     s1_tag;
  logic [SW-1:0] s1_sub;
  logic [RW-1:0] s1_rot;
  logic [AW-1:0] s1_grp;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_tag <= '0;
      s1_sub <= '0;
      s1_rot <= '0;
      s1_grp <= '0;
    end else begin
      s1_tag <= '{vld: mem_rd_o, last: iss_last};
      s1_sub <= iss_sub;
      s1_rot <= iss_rot;
      s1_grp <= iss_grp;
    end
  end

  logic [WORD_W-1:0] picked;
  logic [WORD_W-1:0] rotated;

  skip_subword_mux #(.W(WORD_W), .SUBS(SUBS)) i_mux (
    .col_word(mem_rdata_i), .sel(s1_sub), .word(picked)
  );

  skip_barrel_rot #(.W(WORD_W)) i_rot (
    .din(picked), .amt(s1_rot), .dout(rotated)
  );

  // stage 2: registered output
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_group_o <= '0;
      out_data_o  <= '0;
      done_o      <= 1'b0;
    end else begin
      out_valid_o <= s1_tag.vld;
      done_o      <= s1_tag.vld && s1_tag.last;
      if (s1_tag.vld) begin
        out_group_o <= s1_grp;
        out_data_o  <= rotated;
      end
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
    out_valid_o == $past(mem_rd_o, 2)); // R6

  AST_DONE_LAST: assert property (@(posedge clk) disable iff (rst)
    done_o |-> out_valid_o && (out_group_o == AW'(N-1))); // R7

  AST_GROUP_STEP: assert property (@(posedge clk) disable iff (rst)
    out_valid_o && $past(out_valid_o) |-> out_group_o == $past(out_group_o) + 1'b1); // R7

  AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    !busy_o && !$past(busy_o) |-> !mem_rd_o); // R9
endmodule

// File: tb/test_skip_shift_reader.sv
module test_skip_shift_reader;
  localparam int ROWS = 2, COLS = 2, SUBS = 4, W = 64;
  localparam int N = ROWS * COLS * SUBS;
  localparam int L = N * W;
  localparam int AW = $clog2(N);
  localparam int SHW = AW + $clog2(W);

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [SHW-1:0] shift = '0;
  logic busy, mem_rd, out_valid, done;
  logic [$clog2(ROWS)-1:0] mem_row;
  logic [$clog2(COLS)-1:0] mem_col;
  logic [W*SUBS-1:0] rdata = '0;
  logic [AW-1:0] out_group;
  logic [W-1:0] out_data;

  always #5 clk = ~clk;

  skip_shift_reader #(.ROWS(ROWS), .COLS(COLS), .SUBS(SUBS), .WORD_W(W)) i_skip_shift_reader (
    .clk(clk), .rst(rst), .start_i(start), .shift_i(shift), .busy_o(busy),
    .mem_rd_o(mem_rd), .mem_row_o(mem_row), .mem_col_o(mem_col), .mem_rdata_i(rdata),
    .out_valid_o(out_valid), .out_group_o(out_group), .out_data_o(out_data), .done_o(done)
  );

  int n_chk = 0, n_bad = 0, cycles = 0;
  int cur_shift = 0, iss_cnt = 0, out_cnt = 0, done_seen = 0;
  logic mon_en = 1'b0, rd_d1 = 1'b0, rd_d2 = 1'b0;
  logic [W*SUBS-1:0] mem [ROWS*COLS];

  function automatic logic site_bit(int i);
    logic [31:0] h;
    h = 32'(i) * 32'h9E3779B1;
    h = h ^ (h >> 15);
    return h[7];
  endfunction

  function automatic logic [W-1:0] exp_word(int g, int s);
    logic [W-1:0] e;
    for (int k = 0; k < W; k++) e[k] = site_bit((g + k*N + s) % L);
    return e;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (mem_rd) rdata <= mem[int'(mem_row)*COLS + int'(mem_col)];
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      check(out_valid == rd_d2, "R6 latency", W'(out_valid), W'(rd_d2));
      if (mem_rd) begin
        int lin, er, ec;
        lin = (iss_cnt + (cur_shift % N)) % N;
        er = lin / (COLS*SUBS);
        ec = (lin / SUBS) % COLS;
        check(int'(mem_row) == er && int'(mem_col) == ec, "R4 R5 address",
              W'({mem_row, mem_col}), W'(er*COLS + ec));
        iss_cnt++;
      end
      if (out_valid) begin
        check(int'(out_group) == out_cnt, "R7 group order", W'(out_group), W'(out_cnt));
        check(out_data == exp_word(out_cnt, cur_shift), "R2 R3 data", out_data,
              exp_word(out_cnt, cur_shift));
        if (done) begin
          check(out_cnt == N-1, "R7 done on last", W'(out_cnt), W'(N-1));
          done_seen++;
        end
        out_cnt++;
      end else if (done) begin
        check(1'b0, "R7 done without word", 1, 0);
      end
    end
    rd_d2 = rd_d1;
    rd_d1 = mem_rd;
  end

  task automatic sweep(int s, bit interfere);
    int guard;
    @(negedge clk); #1;
    iss_cnt = 0; out_cnt = 0; done_seen = 0; cur_shift = s;
    start = 1'b1; shift = SHW'(s);
    @(negedge clk); #1;
    start = 1'b0; shift = SHW'(~s);
    check(busy == 1'b1 && mem_rd == 1'b0, "R9 busy before read", W'({busy, mem_rd}), W'(2));
    @(negedge clk); #1;
    check(mem_rd == 1'b1, "R9 first read", W'(mem_rd), 1);
    if (interfere) begin
      repeat (3) @(negedge clk);
      #1 start = 1'b1;
      @(negedge clk); #1 start = 1'b0;  // R8: must not disturb the sweep
    end
    guard = 0;
    while (done_seen == 0 && guard < 4*N) begin
      @(negedge clk); #1;
      guard++;
    end
    repeat (3) @(negedge clk);
    #1;
    check(out_cnt == N && done_seen == 1, "R7 R8 word count", W'(out_cnt), W'(N));
    check(busy == 1'b0 && out_valid == 1'b0, "R8 idle after sweep", W'({busy, out_valid}), 0);
  endtask

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        for (int sb = 0; sb < SUBS; sb++)
          for (int j = 0; j < W; j++)
            mem[r*COLS + c][sb*W + j] = site_bit((r*COLS + c)*SUBS + sb + j*N);
    repeat (4) @(negedge clk);
    check({busy, mem_rd, out_valid, done} == 4'b0, "R1 in reset",
          W'({busy, mem_rd, out_valid, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    check({busy, mem_rd, out_valid, done} == 4'b0, "R1 after reset",
          W'({busy, mem_rd, out_valid, done}), 0);
    mon_en = 1'b1;
    for (int s = 0; s < (1 << SHW); s++) sweep(s, (s % 7) == 3);
    finish_run();
  end
endmodule